// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the register front end of a multi-channel DMA controller. Software drives it through two byte-wide ports. A command byte names an operation and a channel. The data bytes that follow load, or read back, one register of that channel. Each channel holds a 16-bit I/O port address, a 24-bit memory address, a 16-bit transfer count, an 8-bit mode byte and a mask flag.

A byte pointer inside the block walks the bytes of the selected register, low byte first. A separate transfer engine, which is not part of this block, sees a per-channel active flag and a registered view of one channel chosen by `view_ch`. The engine steps a channel's count down with a decrement strobe.

The count holds the number of transfer units minus one. In 16-bit mode the units are words. One programming pass therefore moves at most 65536 units.

Top module: `dma_prog_port`

## Requirements
- R1: On synchronous reset every channel is masked and its registers are zero. `rdata` is 0, `ch_active` is all zero and `view_masked` is 1.
- R2: A command byte carries the operation in bits 7:4 and the channel in bits 3:0. Operation 0x9 masks the named channel and operation 0xA unmasks it. No other channel is touched.
- R3: Operation 0x0 is followed by two data bytes, low then high, that load the channel's 16-bit I/O port address.
- R4: Operation 0x2 is followed by three data bytes (bits 7:0, then 15:8, then 23:16) that load the 24-bit address. Operation 0x3 reads the address back in the same byte order.
- R5: Operation 0x4 is followed by two data bytes, low then high, that load the count. Operation 0x5 reads the remaining count back in the same order.
- R6: Operation 0x7 takes one mode byte. Bit 2 enables the transfer. Bit 3 selects read (0 means write). Bit 0 selects an I/O-port target. Bit 6 selects 16-bit units. These bits appear on `view_enable`-free decoded outputs `view_read`, `view_iotgt` and `view_wide`, and the raw byte appears on `view_mode`.
- R7: Each command byte returns the byte pointer to the first byte of its register. Data bytes beyond the register's length are ignored.
- R8: `ch_active[c]` is 1 only when channel c is unmasked, its mode bit 2 is set, and it has not terminated.
- R9: A decrement strobe to an active channel lowers its count by one. A strobe at count zero terminates the channel: active clears and the count stays 0. A new count or mode byte clears the termination. A strobe to an inactive channel has no effect.
- R10: `rdata` is registered. It changes only in the cycle after a data-port read. A read under 0x3 or 0x5 within the register's length returns the pointed byte and advances the pointer. Any other read returns 0.
- R11: The view outputs show, one cycle later, the registers of the channel that `view_ch` selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_we | input | 1 | command byte strobe; takes priority over data strobes in the same cycle |
| data_we | input | 1 | data byte write strobe |
| data_re | input | 1 | data byte read strobe |
| wdata | input | 8 | byte written by either strobe |
| rdata | output | 8 | registered read-back byte |
| dec_en | input | 1 | count decrement strobe from the transfer engine |
| dec_ch | input | 4 | channel that the decrement strobe applies to |
| view_ch | input | 4 | channel shown on the view outputs |
| ch_active | output | NCH | per-channel active flags |
| view_port | output | PORT_W | I/O port address of the viewed channel |
| view_addr | output | ADDR_W | memory address of the viewed channel |
| view_cnt | output | CNT_W | remaining count of the viewed channel |
| view_mode | output | 8 | raw mode byte of the viewed channel |
| view_read | output | 1 | mode bit 3 of the viewed channel |
| view_iotgt | output | 1 | mode bit 0 of the viewed channel |
| view_wide | output | 1 | mode bit 6 of the viewed channel |
| view_masked | output | 1 | mask flag of the viewed channel |

## Verification
Each result has a fixed delay after its stimulus:
- Register loads, mask changes and count steps take effect at the edge where the strobe is seen, so `ch_active` shows them from that edge on.
- `rdata` and the view outputs take one more register. Each shows the state from before the edge on which it was captured.

The bench model applies every strobe at the same edge as the design. It computes the expected `rdata` and view from the model state before that edge's update. All outputs are compared at the falling edge that follows. The directed checks capture read bytes one edge after the strobe, and view values two edges after a write.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  // channel field width is fixed by the command byte layout (bits 3:0)
  localparam int CH_W = 4;

  // operation codes in command bits 7:4
  localparam logic [3:0] OP_PORT_WR = 4'h0;
  localparam logic [3:0] OP_ADDR_WR = 4'h2;
  localparam logic [3:0] OP_ADDR_RD = 4'h3;
  localparam logic [3:0] OP_CNT_WR  = 4'h4;
  localparam logic [3:0] OP_CNT_RD  = 4'h5;
  localparam logic [3:0] OP_MODE_WR = 4'h7;
  localparam logic [3:0] OP_MASK    = 4'h9;
  localparam logic [3:0] OP_UNMASK  = 4'hA;
  localparam logic [3:0] OP_IDLE    = 4'hF;

  // mode byte bit positions
  localparam int MB_IO   = 0;
  localparam int MB_EN   = 2;
  localparam int MB_RD   = 3;
  localparam int MB_WIDE = 6;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_PORT,
    FLD_ADDR,
    FLD_CNT,
    FLD_MODE
  } fld_e;
endpackage

// File: rtl/dpp_cmd_seq.sv
module dpp_cmd_seq
  import dpp_pkg::*;
#(
  parameter int PORT_B = 2,
  parameter int ADDR_B = 3,
  parameter int CNT_B  = 2,
  parameter int PTR_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             data_we,
  input  logic             data_re,
  input  logic [7:0]       wdata,
  output fld_e             fld,
  output logic [PTR_W-1:0] ptr,
  output logic [CH_W-1:0]  cur_ch,
  output logic             wr_go,
  output logic             rd_go,
  output logic             rd_any,
  output logic             mask_set,
  output logic             mask_clr,
  output logic [CH_W-1:0]  cmd_ch
);
  logic [3:0]       op_q;
  logic [PTR_W-1:0] len;
  logic             wr_op;
  logic             rd_op;
  logic             in_rng;

  always_comb begin
    fld   = FLD_NONE;
    len   = '0;
    wr_op = 1'b0;
    rd_op = 1'b0;
    case (op_q)
      OP_PORT_WR: begin fld = FLD_PORT; len = PTR_W'(PORT_B); wr_op = 1'b1; end
      OP_ADDR_WR: begin fld = FLD_ADDR; len = PTR_W'(ADDR_B); wr_op = 1'b1; end
      OP_ADDR_RD: begin fld = FLD_ADDR; len = PTR_W'(ADDR_B); rd_op = 1'b1; end
      OP_CNT_WR:  begin fld = FLD_CNT;  len = PTR_W'(CNT_B);  wr_op = 1'b1; end
      OP_CNT_RD:  begin fld = FLD_CNT;  len = PTR_W'(CNT_B);  rd_op = 1'b1; end
      OP_MODE_WR: begin fld = FLD_MODE; len = PTR_W'(1);      wr_op = 1'b1; end
      default: ;
    endcase
  end

  assign in_rng   = (ptr < len);
  assign wr_go    = data_we && !cmd_we && wr_op && in_rng;
  assign rd_go    = data_re && !cmd_we && rd_op && in_rng;
  assign rd_any   = data_re && !cmd_we;
  assign cmd_ch   = wdata[CH_W-1:0];
  assign mask_set = cmd_we && (wdata[7:4] == OP_MASK);
  assign mask_clr = cmd_we && (wdata[7:4] == OP_UNMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      cur_ch <= '0;
      ptr    <= '0;
    end else if (cmd_we) begin
      op_q   <= wdata[7:4];
      cur_ch <= wdata[CH_W-1:0];
      ptr    <= '0;
    end else if (wr_go || rd_go) begin
      ptr    <= ptr + 1'b1;
    end
  end

  // R7
  ptr_reset_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> (ptr == '0));

  // R7
  ptr_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= len);
endmodule

// File: rtl/dpp_chan_slot.sv
module dpp_chan_slot
  import dpp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_go,
  input  fld_e              fld,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [7:0]        wbyte,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              dec,
  output logic [PORT_W-1:0] port_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [7:0]        mode_q,
  output logic              masked_q,
  output logic              active
);
  localparam int PORT_B = PORT_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;

  logic term_q;
  logic mine_wr;
  logic dec_hit;

  assign active  = !masked_q && mode_q[MB_EN] && !term_q;
  assign mine_wr = sel && wr_go;
  assign dec_hit = dec && active && !mine_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q   <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      mode_q   <= '0;
      masked_q <= 1'b1;
      term_q   <= 1'b0;
    end else begin
      if (mask_set)      masked_q <= 1'b1;
      else if (mask_clr) masked_q <= 1'b0;

      if (mine_wr) begin
        case (fld)
          FLD_PORT: begin
            for (int b = 0; b < PORT_B; b++)
              if (ptr == PTR_W'(b)) port_q[b*8 +: 8] <= wbyte;
          end
          FLD_ADDR: begin
            for (int b = 0; b < ADDR_B; b++)
              if (ptr == PTR_W'(b)) addr_q[b*8 +: 8] <= wbyte;
          end
          FLD_CNT: begin
            for (int b = 0; b < CNT_B; b++)
              if (ptr == PTR_W'(b)) cnt_q[b*8 +: 8] <= wbyte;
            term_q <= 1'b0;
          end
          FLD_MODE: begin
            mode_q <= wbyte;
            term_q <= 1'b0;
          end
          default: ;
        endcase
      end else if (dec_hit) begin
        if (cnt_q == '0) term_q <= 1'b1;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && cnt_q == '0) |=> (!active && cnt_q == '0));

  // R2
  mask_take_chk: assert property (@(posedge clk) disable iff (rst)
    mask_set |=> (masked_q && !active));
endmodule

// File: rtl/dma_prog_port.sv
module dma_prog_port
  import dpp_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              dec_en,
  input  logic [3:0]        dec_ch,
  input  logic [3:0]        view_ch,
  output logic [NCH-1:0]    ch_active,
  output logic [PORT_W-1:0] view_port,
  output logic [ADDR_W-1:0] view_addr,
  output logic [CNT_W-1:0]  view_cnt,
  output logic [7:0]        view_mode,
  output logic              view_read,
  output logic              view_iotgt,
  output logic              view_wide,
  output logic              view_masked
);
  localparam int PORT_B = PORT_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int CNT_B  = CNT_W / 8;
  localparam int MAXB   = (ADDR_B > PORT_B) ? ((ADDR_B > CNT_B) ? ADDR_B : CNT_B)
                                            : ((PORT_B > CNT_B) ? PORT_B : CNT_B);
  localparam int PTR_W  = $clog2(MAXB + 1);

  fld_e             fld;
  logic [PTR_W-1:0] ptr;
  logic [CH_W-1:0]  cur_ch;
  logic [CH_W-1:0]  cmd_ch;
  logic             wr_go, rd_go, rd_any, mask_set, mask_clr;

  logic [PORT_W-1:0] port_a [NCH];
  logic [ADDR_W-1:0] addr_a [NCH];
  logic [CNT_W-1:0]  cnt_a  [NCH];
  logic [7:0]        mode_a [NCH];
  logic [NCH-1:0]    masked_a;
  logic [7:0]        rd_byte;

  dpp_cmd_seq #(
    .PORT_B(PORT_B), .ADDR_B(ADDR_B), .CNT_B(CNT_B), .PTR_W(PTR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .fld(fld), .ptr(ptr), .cur_ch(cur_ch), .wr_go(wr_go),
    .rd_go(rd_go), .rd_any(rd_any), .mask_set(mask_set), .mask_clr(mask_clr),
    .cmd_ch(cmd_ch)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpp_chan_slot #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W), .PTR_W(PTR_W)
    ) u_slot (
      .clk(clk), .rst(rst),
      .sel(cur_ch == CH_W'(i)),
      .wr_go(wr_go), .fld(fld), .ptr(ptr), .wbyte(wdata),
      .mask_set(mask_set && cmd_ch == CH_W'(i)),
      .mask_clr(mask_clr && cmd_ch == CH_W'(i)),
      .dec(dec_en && dec_ch == CH_W'(i)),
      .port_q(port_a[i]), .addr_q(addr_a[i]), .cnt_q(cnt_a[i]),
      .mode_q(mode_a[i]), .masked_q(masked_a[i]), .active(ch_active[i])
    );
  end

  // read-back byte selection for the current channel and pointer
  always_comb begin
    rd_byte = 8'h00;
    if (fld == FLD_ADDR) begin
      for (int b = 0; b < ADDR_B; b++)
        if (ptr == PTR_W'(b)) rd_byte = addr_a[cur_ch][b*8 +: 8];
    end else if (fld == FLD_CNT) begin
      for (int b = 0; b < CNT_B; b++)
        if (ptr == PTR_W'(b)) rd_byte = cnt_a[cur_ch][b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= 8'h00;
    else if (rd_go)  rdata <= rd_byte;
    else if (rd_any) rdata <= 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view_port   <= '0;
      view_addr   <= '0;
      view_cnt    <= '0;
      view_mode   <= '0;
      view_read   <= 1'b0;
      view_iotgt  <= 1'b0;
      view_wide   <= 1'b0;
      view_masked <= 1'b1;
    end else begin
      view_port   <= port_a[view_ch];
      view_addr   <= addr_a[view_ch];
      view_cnt    <= cnt_a[view_ch];
      view_mode   <= mode_a[view_ch];
      view_read   <= mode_a[view_ch][MB_RD];
      view_iotgt  <= mode_a[view_ch][MB_IO];
      view_wide   <= mode_a[view_ch][MB_WIDE];
      view_masked <= masked_a[view_ch];
    end
  end

  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_any && !rd_go) |=> (rdata == 8'h00));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(rdata));
endmodule

// File: tb/dma_prog_port_tb.sv
`timescale 1ns/1ps
module dma_prog_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0, data_we = 1'b0, data_re = 1'b0, dec_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [3:0]  dec_ch = 4'h0, view_ch = 4'h0;
  logic [7:0]  rdata;
  logic [15:0] ch_active;
  logic [15:0] view_port;
  logic [23:0] view_addr;
  logic [15:0] view_cnt;
  logic [7:0]  view_mode;
  logic        view_read, view_iotgt, view_wide, view_masked;

  always #10 clk = ~clk;

  dma_prog_port u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rdata(rdata), .dec_en(dec_en), .dec_ch(dec_ch),
    .view_ch(view_ch), .ch_active(ch_active), .view_port(view_port),
    .view_addr(view_addr), .view_cnt(view_cnt), .view_mode(view_mode),
    .view_read(view_read), .view_iotgt(view_iotgt), .view_wide(view_wide),
    .view_masked(view_masked)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_port[16], m_addr[16], m_cnt[16], m_mode[16];
  bit          m_mask[16], m_term[16];
  int          m_op, m_ch, m_ptr;
  bit          started = 0;
  logic [7:0]  e_rdata;
  int unsigned e_port, e_addr, e_cnt, e_mode;
  bit          e_masked;

  function automatic bit m_act(int c);
    return !m_mask[c] && ((m_mode[c] >> 2) & 1) == 1 && !m_term[c];
  endfunction

  function automatic int op_len(int op);
    case (op)
      0: return 2;
      2: return 3;
      3: return 3;
      4: return 2;
      5: return 2;
      7: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned put_byte(int unsigned v, int p, logic [7:0] b);
    return (v & ~(32'hFF << (8 * p))) | (32'(b) << (8 * p));
  endfunction

  always @(posedge clk) begin
    bit act_pre[16];
    bit wr;
    started = 1;
    if (rst) begin
      for (int c = 0; c < 16; c++) begin
        m_port[c] = 0; m_addr[c] = 0; m_cnt[c] = 0; m_mode[c] = 0;
        m_mask[c] = 1; m_term[c] = 0;
      end
      m_op = 15; m_ch = 0; m_ptr = 0;
      e_rdata = 8'h00; e_port = 0; e_addr = 0; e_cnt = 0; e_mode = 0; e_masked = 1;
    end else begin
      for (int c = 0; c < 16; c++) act_pre[c] = m_act(c);
      e_port = m_port[view_ch]; e_addr = m_addr[view_ch];
      e_cnt = m_cnt[view_ch]; e_mode = m_mode[view_ch]; e_masked = m_mask[view_ch];
      wr = 0;
      if (cmd_we) begin
        m_op = int'(wdata[7:4]); m_ch = int'(wdata[3:0]); m_ptr = 0;
        if (m_op == 9)  m_mask[m_ch] = 1;
        if (m_op == 10) m_mask[m_ch] = 0;
      end else begin
        if (data_we && (m_op == 0 || m_op == 2 || m_op == 4 || m_op == 7)
            && m_ptr < op_len(m_op)) begin
          wr = 1;
          case (m_op)
            0: m_port[m_ch] = put_byte(m_port[m_ch], m_ptr, wdata);
            2: m_addr[m_ch] = put_byte(m_addr[m_ch], m_ptr, wdata);
            4: begin m_cnt[m_ch] = put_byte(m_cnt[m_ch], m_ptr, wdata); m_term[m_ch] = 0; end
            default: begin m_mode[m_ch] = wdata; m_term[m_ch] = 0; end
          endcase
          m_ptr++;
        end
        if (data_re) begin
          if ((m_op == 3 || m_op == 5) && m_ptr < op_len(m_op)) begin
            e_rdata = 8'((((m_op == 3) ? m_addr[m_ch] : m_cnt[m_ch]) >> (8 * m_ptr)) & 255);
            m_ptr++;
          end else begin
            e_rdata = 8'h00;
          end
        end
      end
      if (dec_en && act_pre[dec_ch] && !(wr && m_ch == int'(dec_ch))) begin
        if (m_cnt[dec_ch] == 0) m_term[dec_ch] = 1;
        else                    m_cnt[dec_ch]  = m_cnt[dec_ch] - 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [15:0] e_act;
    if (started && !rst) begin
      for (int c = 0; c < 16; c++) e_act[c] = m_act(c);
      chk("R10 rdata", 32'(rdata), 32'(e_rdata));
      chk("R8 ch_active", 32'(ch_active), 32'(e_act));
      chk("R11 view_port", 32'(view_port), e_port);
      chk("R11 view_addr", 32'(view_addr), e_addr);
      chk("R11 view_cnt", 32'(view_cnt), e_cnt);
      chk("R11 view_mode", 32'(view_mode), e_mode);
      chk("R6 view_read", 32'(view_read), (e_mode >> 3) & 1);
      chk("R6 view_iotgt", 32'(view_iotgt), e_mode & 1);
      chk("R6 view_wide", 32'(view_wide), (e_mode >> 6) & 1);
      chk("R11 view_masked", 32'(view_masked), 32'(e_masked));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_cmd(input logic [7:0] b);
    cmd_we = 1'b1; wdata = b; @(negedge clk); cmd_we = 1'b0;
  endtask
  task automatic wr_dat(input logic [7:0] b);
    data_we = 1'b1; wdata = b; @(negedge clk); data_we = 1'b0;
  endtask
  task automatic rd_dat(output logic [7:0] v);
    data_re = 1'b1; @(negedge clk); data_re = 1'b0; v = rdata;
  endtask
  task automatic dec_pulse();
    dec_en = 1'b1; @(negedge clk); dec_en = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 active", 32'(ch_active), 0);
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 masked", 32'(view_masked), 1);

    view_ch = 4'd5;
    // R3 port address on channel 5
    wr_cmd(8'h95); wr_cmd(8'h05); wr_dat(8'h34); wr_dat(8'h12); idle(2);
    chk("R3 port", 32'(view_port), 32'h1234);

    // R4 address, extra byte ignored (R7)
    wr_cmd(8'h25); wr_dat(8'h56); wr_dat(8'h34); wr_dat(8'h12); wr_dat(8'hFF);
    wr_cmd(8'h35);
    rd_dat(v); chk("R4 addr byte0", 32'(v), 32'h56);
    rd_dat(v); chk("R4 addr byte1", 32'(v), 32'h34);
    rd_dat(v); chk("R4 addr byte2", 32'(v), 32'h12);
    rd_dat(v); chk("R10 read past end", 32'(v), 0);
    idle(1);
    chk("R7 extra byte ignored", 32'(view_addr), 32'h123456);

    // R5 count
    wr_cmd(8'h45); wr_dat(8'h03); wr_dat(8'h00);
    wr_cmd(8'h55);
    rd_dat(v); chk("R5 cnt low", 32'(v), 32'h03);
    rd_dat(v); chk("R5 cnt high", 32'(v), 32'h00);

    // R6 mode bits, channel still masked (R8)
    wr_cmd(8'h75); wr_dat(8'h4D); idle(2);
    chk("R6 read", 32'(view_read), 1);
    chk("R6 iotgt", 32'(view_iotgt), 1);
    chk("R6 wide", 32'(view_wide), 1);
    chk("R8 masked inactive", 32'(ch_active), 0);
    wr_cmd(8'hA5); idle(1);
    chk("R2 unmask ch5", 32'(ch_active), 32'h0020);

    // R7 new command restarts the pointer
    wr_cmd(8'h45); wr_dat(8'h07); wr_cmd(8'h45); wr_dat(8'h02); wr_dat(8'h00);
    wr_cmd(8'h55);
    rd_dat(v); chk("R7 restart low", 32'(v), 32'h02);
    rd_dat(v); chk("R7 restart high", 32'(v), 32'h00);

    // R9 decrement to terminal
    dec_ch = 4'd5;
    dec_pulse(); dec_pulse();
    chk("R9 active at zero", 32'(ch_active[5]), 1);
    dec_pulse();
    chk("R9 terminated", 32'(ch_active[5]), 0);
    dec_pulse();
    wr_cmd(8'h55);
    rd_dat(v); chk("R9 count held low", 32'(v), 0);
    rd_dat(v); chk("R9 count held high", 32'(v), 0);
    wr_cmd(8'h45); wr_dat(8'h01); wr_dat(8'h00);
    chk("R9 rearmed", 32'(ch_active[5]), 1);

    // R9 strobe on masked channel ignored
    wr_cmd(8'h95); dec_pulse();
    wr_cmd(8'h55);
    rd_dat(v); chk("R9 masked dec ignored", 32'(v), 32'h01);

    // channel 0 write mode, 8-bit
    view_ch = 4'd0;
    wr_cmd(8'h70); wr_dat(8'h04); idle(2);
    chk("R6 write dir", 32'(view_read), 0);
    chk("R6 byte units", 32'(view_wide), 0);
    chk("R8 both masked", 32'(ch_active), 0);
    wr_cmd(8'hA0);
    chk("R2 unmask ch0", 32'(ch_active), 32'h0001);
    wr_cmd(8'h9F);
    chk("R2 mask ch15 only", 32'(ch_active), 32'h0001);
    wr_cmd(8'h70); wr_dat(8'h00);
    chk("R8 enable cleared", 32'(ch_active), 0);

    // R10 read under a non-readback operation
    wr_cmd(8'h00);
    rd_dat(v); chk("R10 non-readback", 32'(v), 0);

    // R11 view follows selection one cycle later
    view_ch = 4'd5; @(negedge clk);
    chk("R11 view switch", 32'(view_addr), 32'h123456);

    idle(2);
    summary();
  end
endmodule